// File: doc/BRIEF.md
# Reprogrammable Threshold Clock Divider

This block divides a stream of enable ticks, typically produced by a phase accumulator, down to a slower pulse train. An up-counter advances on every enabled tick. When a tick arrives with the counter already equal to the programmed limit, the block emits a one-clock output pulse and the counter starts again from zero. The output period is therefore limit+1 enabled ticks.

The limit can be rewritten at any time through a write strobe. The new value is applied in the same clock cycle as the write. No periods are lost and no spurious short pulse is produced. If the new limit is above the running count, counting simply continues towards the new limit. If the new limit is at or below the running count, the period is already over: the block emits one pulse at once and restarts from zero. Because a change never needs to wait for the old period to end, a frequency change takes hold within one master clock.

Top module: `reprog_divider`

## Requirements
- R1: A synchronous active-high reset clears the count to 0, loads a limit of 0 and holds the pulse output low in the cycle after reset.
- R2: With limit L and no writes, the pulse output goes high for exactly one clock once in every L+1 enabled ticks. The pulse is registered and appears in the clock after the tick that completes the period.
- R3: In a clock with neither an enabled tick nor a write, the count does not change and no pulse is produced.
- R4: Writing a limit strictly greater than the current count produces no pulse, and the count is not restarted. The next pulse follows the tick that takes the count to the new limit: N−C ticks later if the write clock also carries a tick, N−C+1 ticks later if it does not.
- R5: Writing a limit less than or equal to the current count produces a pulse in the next clock, whether or not a tick is present, and restarts the count at 0. The comparison is unsigned over the full 32-bit width.
- R6: A write that coincides with a tick completing the period yields a single pulse. The following period uses the newly written limit.
- R7: A written limit governs the tick in the same clock as the write.
- R8: With a limit of 0, every enabled tick produces a pulse, including back-to-back ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Count enable, one enabled tick per clock when high |
| lim_wr | input | 1 | Write strobe for the limit |
| lim_val | input | 32 | New limit value, taken when lim_wr is high |
| pulse_o | output | 1 | Registered output pulse, one clock wide |

## Verification
The assertions check on every clock that the count never exceeds the stored limit and that the count holds while the clock carries neither a tick nor a write. They also check that a lowering write always yields a pulse and a restart, that a raising write with a tick advances the count without a pulse, that every pulse coincides with a zeroed count, and that reset leaves a clean state.

The actual pulse spacing for each limit can only be shown by the bench's scenarios. The same holds for the number of ticks remaining after a write at every count position, and for the single pulse when a write lands on a terminal tick. The bench sweeps small limits and every write position within a period, and computes the expected pulse positions arithmetically.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
  // reason an output edge is produced in a given clock
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_WRAP = 2'd1,
    EV_DROP = 2'd2
  } edge_cause_e;
endpackage

// File: rtl/rdiv_limit_reg.sv
module rdiv_limit_reg #(
  parameter int unsigned    W       = 32,
  parameter logic [W-1:0]   DEF_LIM = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] lim_q,
  output logic [W-1:0] lim_eff
);
  // a write applies to the decision in its own clock
  always_comb lim_eff = wr ? wr_val : lim_q;

  always_ff @(posedge clk) begin
    if (rst) lim_q <= DEF_LIM;
    else     lim_q <= lim_eff;
  end
endmodule

// File: rtl/rdiv_counter.sv
module rdiv_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         clear,
  output logic [W-1:0] cnt_q
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (tick)    cnt_q <= cnt_q + ONE;
  end
endmodule

// File: rtl/rdiv_edge.sv
module rdiv_edge
  import rdiv_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         wr,
  input  logic [W-1:0] wr_val,
  input  logic [W-1:0] lim_eff,
  input  logic [W-1:0] cnt,
  output edge_cause_e  cause,
  output logic         fire,
  output logic         pulse_q
);
  logic drop, wrap;

  always_comb begin
    drop = wr && (wr_val <= cnt);
    wrap = tick && (cnt >= lim_eff);
    fire = drop || wrap;
    if (drop)      cause = EV_DROP;
    else if (wrap) cause = EV_WRAP;
    else           cause = EV_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= fire;
  end
endmodule

// File: rtl/reprog_divider.sv
module reprog_divider
  import rdiv_pkg::*;
#(
  parameter int unsigned  LIM_W   = 32,
  parameter logic [LIM_W-1:0] DEF_LIM = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             lim_wr,
  input  logic [LIM_W-1:0] lim_val,
  output logic             pulse_o
);
  logic [LIM_W-1:0] lim_q, lim_eff, cnt_q;
  logic             fire;
  edge_cause_e      cause;

  rdiv_limit_reg #(.W(LIM_W), .DEF_LIM(DEF_LIM)) u_lim (
    .clk(clk), .rst(rst), .wr(lim_wr), .wr_val(lim_val),
    .lim_q(lim_q), .lim_eff(lim_eff)
  );

  rdiv_counter #(.W(LIM_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick_en), .clear(fire), .cnt_q(cnt_q)
  );

  rdiv_edge #(.W(LIM_W)) u_edge (
    .clk(clk), .rst(rst), .tick(tick_en), .wr(lim_wr), .wr_val(lim_val),
    .lim_eff(lim_eff), .cnt(cnt_q), .cause(cause), .fire(fire),
    .pulse_q(pulse_o)
  );

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (cnt_q == '0) && (lim_q == DEF_LIM) && !pulse_o); // R1

  AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= lim_q); // R2

  AST_PULSE_RESTART: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> (cnt_q == '0)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !lim_wr) |=> ($stable(cnt_q) && !pulse_o)); // R3

  AST_RAISE_CONTINUES: assert property (@(posedge clk) disable iff (rst)
    (lim_wr && tick_en && (lim_val > cnt_q)) |=>
      (!pulse_o && (cnt_q == $past(cnt_q) + 1'b1))); // R4

  AST_LOWER_FIRES: assert property (@(posedge clk) disable iff (rst)
    (lim_wr && (lim_val <= cnt_q)) |=> (pulse_o && (cnt_q == '0))); // R5

  AST_DROP_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (cause == EV_DROP) |=> (lim_q == $past(lim_val))); // R6
endmodule

// File: tb/test_reprog_divider.sv
module test_reprog_divider;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        lim_wr = 1'b0;
  logic [31:0] lim_val = '0;
  logic        pulse_o;

  int vectors = 0;
  int errors  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reprog_divider i_reprog_divider (
    .clk(clk), .rst(rst), .tick_en(tick_en), .lim_wr(lim_wr),
    .lim_val(lim_val), .pulse_o(pulse_o)
  );

  task automatic step(input logic t, input logic w, input logic [31:0] v,
                      input logic exp, input string req);
    @(negedge clk);
    tick_en = t; lim_wr = w; lim_val = v;
    @(posedge clk);
    #1;
    vectors++;
    if (pulse_o !== exp) begin
      errors++;
      $display("FAIL %s: pulse_o=%b expected %b (t=%0t)", req, pulse_o, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; tick_en = 1'b0; lim_wr = 1'b0;
    @(posedge clk);
    #1;
    vectors++;
    if (pulse_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: pulse_o=%b expected 0 after reset", pulse_o);
    end
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    // R1 / R8: default limit 0 pulses on every tick
    do_reset();
    step(1'b0, 1'b0, '0, 1'b0, "R1");
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, '0, 1'b1, "R8");
    step(1'b0, 1'b0, '0, 1'b0, "R3");

    // R2 / R3: period sweep, continuous and gapped ticks
    for (int lim = 0; lim <= 12; lim++) begin
      do_reset();
      // writing lim at count 0 fires only when lim is 0 (R5)
      step(1'b0, 1'b1, 32'(lim), (lim == 0), "R5");
      for (int i = 1; i <= 3 * (lim + 1); i++)
        step(1'b1, 1'b0, '0, (i % (lim + 1)) == 0, "R2");
      for (int i = 1; i <= 2 * (lim + 1); i++) begin
        step(1'b0, 1'b0, '0, 1'b0, "R3");
        step(1'b1, 1'b0, '0, (i % (lim + 1)) == 0, "R2");
      end
    end

    // R4 / R5 / R6 / R7: write at every count position of a period
    for (int wt = 0; wt < 2; wt++) begin
      for (int k = 0; k <= 8; k++) begin
        for (int n = 0; n <= 12; n++) begin
          int rem;
          do_reset();
          step(1'b0, 1'b1, 32'd8, 1'b0, "R7");
          for (int i = 0; i < k; i++) step(1'b1, 1'b0, '0, 1'b0, "R2");
          if (n <= k) begin
            step(wt[0], 1'b1, 32'(n), 1'b1, (k == 8 && wt == 1) ? "R6" : "R5");
            rem = n + 1;
          end else begin
            step(wt[0], 1'b1, 32'(n), 1'b0, "R4");
            rem = (wt == 1) ? (n - k) : (n - k + 1);
          end
          for (int i = 1; i <= rem; i++)
            step(1'b1, 1'b0, '0, i == rem, (n <= k) ? "R6" : "R4");
        end
      end
    end

    // R5: full-width unsigned compare
    do_reset();
    step(1'b0, 1'b1, 32'hFFFF_FFFF, 1'b0, "R4");
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, '0, 1'b0, "R4");
    step(1'b0, 1'b1, 32'h8000_0000, 1'b0, "R4");
    step(1'b0, 1'b1, 32'd16, 1'b1, "R5");
    for (int i = 1; i <= 17; i++) step(1'b1, 1'b0, '0, i == 17, "R5");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule